// File: doc/BRIEF.md
# Read-Serviced Watchdog Timer

This block watches for software that stops responding. Software keeps it quiet by reading the module's status/control register often enough. Each such read restarts an internal cycle counter. If no read arrives within the selected timeout, the block raises a one-cycle interrupt event for the interrupt controller. It then starts a new period, so an unserviced system sees the event again every period.

A 2-bit select input chooses the period. Code 00 turns the watchdog off. The other three codes pick a long, a short or a medium timeout, in that order, so the timeout does not grow with the code value. Each period is a parameter given in clock cycles, which keeps simulation short. The bus decode that produces the read strobe and the interrupt controller that consumes the event both sit outside this block.

Top module: `svc_watchdog`

## Requirements
- R1: While `periodSel` is 2'b00 the count is held at zero and `wdogEvent` stays low.
- R2: With `periodSel` = 2'b01 and no servicing, `wdogEvent` rises exactly PER_LONG cycles after the count restarts.
- R3: With `periodSel` = 2'b10 and no servicing, `wdogEvent` rises exactly PER_SHORT cycles after the count restarts.
- R4: With `periodSel` = 2'b11 and no servicing, `wdogEvent` rises exactly PER_MID cycles after the count restarts.
- R5: A cycle with `statusRead` high restarts the count from zero, and no event follows in the next cycle.
- R6: `wdogEvent` is high for a single cycle. If the watchdog is still not serviced, the event repeats once every period.
- R7: A change of `periodSel` restarts the count from zero under the new period.
- R8: While `rstN` is low, `wdogEvent` is low and the count is zero.
- R9: A status read in the cycle where the count reaches its last value wins over the timeout, so no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| periodSel | input | 2 | Timeout select: 00 off, 01 long, 10 short, 11 medium |
| statusRead | input | 1 | One cycle per read of the status/control register |
| wdogEvent | output | 1 | One-cycle interrupt event on timeout |

## Verification
The assertions check these behaviours on every cycle:
- the count is held at zero and the event stays low while the watchdog is off;
- a read or a select change clears the count on the next edge;
- an event never lasts longer than one cycle;
- an event appears only right after the count sat at the last value of the period in force.

Only the bench's scenarios show the timing that spans many cycles:
- the exact period for each code;
- repeated firing when nothing services the block;
- that regular reads suppress every event;
- that a read exactly on the terminal cycle wins over the timeout.

The bench shows these by comparing the output against a behavioural model on every clock.

// File: rtl/svc_wdog_pkg.sv
package svc_wdog_pkg;

  typedef struct packed {
    logic hold;     // watchdog off: clear and keep count at zero
    logic restart;  // service or select change: count from zero
    logic expire;   // terminal count reached without service
  } wdogStrobe_t;

  localparam logic [1:0] SEL_OFF   = 2'b00;
  localparam logic [1:0] SEL_LONG  = 2'b01;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_MID   = 2'b11;

endpackage

// File: rtl/svc_wdog_dp.sv
module svc_wdog_dp
  import svc_wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PER_LONG  = 40,
  parameter int unsigned PER_SHORT = 10,
  parameter int unsigned PER_MID   = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       periodSel,
  input  wdogStrobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             atTerm
);

  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(PER_LONG - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(PER_SHORT - 1);
  localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(PER_MID - 1);

  logic [CNT_W-1:0] lastVal;

  always_comb begin
    unique case (periodSel)
      SEL_LONG:  lastVal = LAST_LONG;
      SEL_SHORT: lastVal = LAST_SHORT;
      SEL_MID:   lastVal = LAST_MID;
      default:   lastVal = '0;
    endcase
  end

  assign atTerm = (count == lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.hold || strobe.restart || strobe.expire) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/svc_wdog_ctrl.sv
module svc_wdog_ctrl
  import svc_wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  periodSel,
  input  logic        statusRead,
  input  logic        atTerm,
  output wdogStrobe_t strobe,
  output logic        wdogEvent
);

  logic [1:0] selQ;

  always_comb begin
    strobe.hold    = (periodSel == SEL_OFF);
    strobe.restart = !strobe.hold && ((periodSel != selQ) || statusRead);
    strobe.expire  = !strobe.hold && !strobe.restart && atTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ      <= SEL_OFF;
      wdogEvent <= 1'b0;
    end else begin
      selQ      <= periodSel;
      wdogEvent <= strobe.expire;
    end
  end

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog #(
  parameter int unsigned PER_LONG  = 820_000_000,
  parameter int unsigned PER_SHORT = 12_800_000,
  parameter int unsigned PER_MID   = 102_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] periodSel,
  input  logic       statusRead,
  output logic       wdogEvent
);
  import svc_wdog_pkg::*;

  localparam int unsigned PER_MAX_LS = (PER_LONG > PER_SHORT) ? PER_LONG : PER_SHORT;
  localparam int unsigned PER_MAX    = (PER_MAX_LS > PER_MID) ? PER_MAX_LS : PER_MID;
  localparam int unsigned CNT_W      = $clog2(PER_MAX + 1);

  wdogStrobe_t      strobe;
  logic [CNT_W-1:0] countVal;
  logic             atTerm;

  svc_wdog_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .periodSel  (periodSel),
    .statusRead (statusRead),
    .atTerm     (atTerm),
    .strobe     (strobe),
    .wdogEvent  (wdogEvent)
  );

  svc_wdog_dp #(
    .CNT_W     (CNT_W),
    .PER_LONG  (PER_LONG),
    .PER_SHORT (PER_SHORT),
    .PER_MID   (PER_MID)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .periodSel (periodSel),
    .strobe    (strobe),
    .count     (countVal),
    .atTerm    (atTerm)
  );

endmodule

// File: rtl/svc_watchdog_chk.sv
module svc_watchdog_chk #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PER_LONG  = 40,
  parameter int unsigned PER_SHORT = 10,
  parameter int unsigned PER_MID   = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       periodSel,
  input logic             statusRead,
  input logic             wdogEvent,
  input logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] lastOf(input logic [1:0] sel);
    case (sel)
      2'b01:   lastOf = CNT_W'(PER_LONG - 1);
      2'b10:   lastOf = CNT_W'(PER_SHORT - 1);
      2'b11:   lastOf = CNT_W'(PER_MID - 1);
      default: lastOf = '0;
    endcase
  endfunction

  // R8: reset values
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_clear_r8: assert (count == '0 && !wdogEvent)
        else $error("reset state not clear");
    end
  end

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (periodSel == 2'b00) |=> (count == '0 && !wdogEvent));

  p_read_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && periodSel != 2'b00) |=> (count == '0 && !wdogEvent));

  p_sel_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(periodSel) |=> (count == '0));

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdogEvent |=> !wdogEvent);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (periodSel != 2'b00 && $stable(periodSel)) |-> (count <= lastOf(periodSel)));

  p_event_at_term_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdogEvent |-> ($past(count) == lastOf($past(periodSel)) && !$past(statusRead)));

endmodule

bind svc_watchdog svc_watchdog_chk #(
  .CNT_W     (CNT_W),
  .PER_LONG  (PER_LONG),
  .PER_SHORT (PER_SHORT),
  .PER_MID   (PER_MID)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .periodSel  (periodSel),
  .statusRead (statusRead),
  .wdogEvent  (wdogEvent),
  .count      (countVal)
);

// File: tb/svc_watchdog_bench.sv
module svc_watchdog_bench;

  localparam int P_LONG  = 40;
  localparam int P_SHORT = 10;
  localparam int P_MID   = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] periodSel = 2'b00;
  logic       statusRead = 1'b0;
  logic       wdogEvent;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int evCount = 0;
  string curReq = "R8";

  // behavioural model state
  int  mCount = 0;
  int  mSelPrev = 0;
  logic mEvent = 1'b0;

  always #5 clk = ~clk;

  svc_watchdog #(
    .PER_LONG  (P_LONG),
    .PER_SHORT (P_SHORT),
    .PER_MID   (P_MID)
  ) u_svc_watchdog (
    .clk        (clk),
    .rstN       (rstN),
    .periodSel  (periodSel),
    .statusRead (statusRead),
    .wdogEvent  (wdogEvent)
  );

  function automatic int periodOf(input int sel);
    case (sel)
      1: return P_LONG;
      2: return P_SHORT;
      3: return P_MID;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount <= 0; mSelPrev <= 0; mEvent <= 1'b0;
    end else begin
      mSelPrev <= int'(periodSel);
      mEvent <= 1'b0;
      if (periodSel == 2'b00) mCount <= 0;
      else if (int'(periodSel) != mSelPrev || statusRead) mCount <= 0;
      else if (mCount + 1 >= periodOf(int'(periodSel))) begin
        mCount <= 0; mEvent <= 1'b1;
      end else mCount <= mCount + 1;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    compared++;
    if (wdogEvent !== mEvent) begin
      mismatched++;
      $display("FAIL %s: cycle %0d wdogEvent actual %b expected %b",
               curReq, cycles, wdogEvent, mEvent);
    end
    if (wdogEvent === 1'b1) evCount++;
    if (cycles > 5000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 5000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expectEvents(input string req, input int exp);
    compared++;
    if (evCount != exp) begin
      mismatched++;
      $display("FAIL %s: event count actual %0d expected %0d", req, evCount, exp);
    end
  endtask

  initial begin
    // R8: reset state
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1: off code, long stretch, no event
    curReq = "R1"; evCount = 0;
    idle(100);
    expectEvents("R1", 0);

    // R2 and R6: long period, two unserviced periods
    curReq = "R2"; evCount = 0;
    periodSel = 2'b01;
    idle(2 * P_LONG + 3);
    expectEvents("R2", 2);

    // R3: short period
    curReq = "R3"; evCount = 0;
    periodSel = 2'b10;
    idle(3 * P_SHORT + 2);
    expectEvents("R3", 3);

    // R4: medium period
    curReq = "R4"; evCount = 0;
    periodSel = 2'b11;
    idle(P_MID + 2);
    expectEvents("R4", 1);

    // R5: regular reads keep it quiet
    curReq = "R5"; evCount = 0;
    periodSel = 2'b10;
    for (int k = 0; k < 8; k++) begin
      idle(P_SHORT - 3);
      statusRead = 1'b1; idle(1); statusRead = 1'b0;
    end
    expectEvents("R5", 0);

    // R9: read lands on the terminal count cycle
    curReq = "R9"; evCount = 0;
    statusRead = 1'b1; idle(1); statusRead = 1'b0;   // count restarts
    idle(P_SHORT - 1);                                 // count now at last value
    statusRead = 1'b1; idle(1); statusRead = 1'b0;
    idle(P_SHORT - 2);
    expectEvents("R9", 0);

    // R7: select change mid-count restarts under new period
    curReq = "R7"; evCount = 0;
    periodSel = 2'b11;
    idle(P_MID - 5);
    periodSel = 2'b10;
    idle(P_SHORT - 1);
    expectEvents("R7", 0);
    idle(3);
    expectEvents("R7", 1);

    // R6: back-to-back repeats
    curReq = "R6"; evCount = 0;
    idle(2 * P_SHORT);
    expectEvents("R6", 2);

    // R1: switching off mid-count
    curReq = "R1"; evCount = 0;
    idle(4);
    periodSel = 2'b00;
    idle(60);
    expectEvents("R1", 0);

    // R8: reset in the middle of a period
    curReq = "R8"; evCount = 0;
    periodSel = 2'b10;
    idle(P_SHORT - 4);
    rstN = 1'b0;
    idle(3);
    expectEvents("R8", 0);
    rstN = 1'b1;
    idle(P_SHORT + 3);
    expectEvents("R8", 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule